// File: doc/BRIEF.md
# Rail Fault Shutdown Supervisor

This block supervises a multi-rail panel power supply. It receives digital short-detect flags for the boost rail, the positive charge pump, the negative charge pump and the logic rail. It also receives an over-temperature flag, a flag confirming that the delayed output switch has been pulled low, a sequence-complete flag and the main enable. A persistent short, or a delayed switch that is still not low once sequencing has finished, opens a timed fault window. The supply is switched off only when the fault is still present at the end of that window. A short that disappears earlier only resets the window.

The block has two shutdown scopes. A boost or pump fault switches off the main rails and leaves the logic rail running. A logic-rail fault switches off every rail. Over-temperature latches a full shutdown on the next clock edge, without a window. Every shutdown is latched and reported on a two-bit class output. A latch is released only by a low-to-high cycle of the main enable or by reset.

States of the controller:
- OFF: enable is low.
- ARMED: running with no fault.
- WINDOW: a main-scope fault is being timed.
- MAIN_TRIP: main rails latched off.
- LOGIC_WINDOW: a logic fault is being timed while main rails are latched off.
- ALL_TRIP: every rail latched off.
- HOT_TRIP: thermal latch.

Transitions between states:
- OFF→ARMED on enable high.
- ARMED→WINDOW on any fault.
- WINDOW→ARMED when the fault clears.
- WINDOW→MAIN_TRIP or ALL_TRIP on window expiry.
- MAIN_TRIP→LOGIC_WINDOW on a logic fault.
- LOGIC_WINDOW→MAIN_TRIP when the logic fault clears or enable drops.
- LOGIC_WINDOW→ALL_TRIP on expiry.
- ARMED or WINDOW→OFF on enable low.
- Any state→HOT_TRIP on over-temperature.
- Any latched state→ARMED on an enable rising edge.

Top module: `rail_fault_supervisor`

## Requirements
- R1: After reset, and until enable is seen high, main_off is 1, logic_off is 0 and fault_class is 00. One clock edge with enable high clears main_off.
- R2: A boost or pump fault flag held continuously trips the block on the (WIN_CYCLES+1)-th clock edge after it is raised. The trip sets main_off=1, keeps logic_off=0 and sets fault_class=01. After WIN_CYCLES edges nothing has tripped.
- R3: If every fault flag clears before the window expires, no shutdown occurs and the window restarts from zero. A later fault again needs the full WIN_CYCLES+1 edges to trip.
- R4: A logic-rail fault that persists through the window sets main_off=1, logic_off=1 and fault_class=10.
- R5: Over-temperature sets main_off=1, logic_off=1 and fault_class=11 on the next clock edge. This latch stays set after the flag drops.
- R6: With the sequence-complete flag high and the delayed-switch-low flag low, the window runs as for a main-scope fault and trips with fault_class=01. With the delayed-switch-low flag high, no trip occurs.
- R7: A latched shutdown holds while enable is low. Enable returning high releases it: one edge after the rise, main_off=0, logic_off=0 and fault_class=00.
- R8: While main rails are latched off, a logic fault persisting WIN_CYCLES+1 edges upgrades the latch to fault_class=10 with logic_off=1.
- R9: Over-temperature takes priority over window expiry in the same cycle and over release by enable. While the flag is high, fault_class stays 11.
- R10: While enable is low and no latch is set, the rail fault flags have no effect. main_off stays 1, logic_off stays 0 and fault_class stays 00, and no window runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset (power cycle) |
| en | input | 1 | Main enable for boost, pumps and slicing |
| seq_done | input | 1 | Power-up sequence finished |
| dsw_low | input | 1 | Delayed output switch confirmed pulled low |
| short_boost | input | 1 | Boost rail short flag |
| short_ppump | input | 1 | Positive pump short flag |
| short_npump | input | 1 | Negative pump short flag |
| short_logic | input | 1 | Logic rail short flag |
| over_temp | input | 1 | Die over-temperature flag |
| main_off | output | 1 | Shut down boost and both pumps |
| logic_off | output | 1 | Shut down the logic rail |
| fault_class | output | 2 | Latched cause: 00 none, 01 main, 10 logic, 11 thermal |

## Verification
Window expiry and the thermal trip can fall in the same clock cycle, as can an enable release and a thermal trip. The bench holds a boost fault for exactly WIN_CYCLES edges and raises over-temperature so that both are seen on the expiry edge. It then expects class 11, not 01. It also toggles enable while over-temperature is still high and expects the thermal latch to survive the rising edge.

// File: rtl/rail_fault_supervisor_pkg.sv
package rail_fault_supervisor_pkg;

    typedef enum logic [2:0] {
        SUP_OFF          = 3'd0,
        SUP_ARMED        = 3'd1,
        SUP_WINDOW       = 3'd2,
        SUP_MAIN_TRIP    = 3'd3,
        SUP_LOGIC_WINDOW = 3'd4,
        SUP_ALL_TRIP     = 3'd5,
        SUP_HOT_TRIP     = 3'd6
    } sup_state_t;

    typedef enum logic [1:0] {
        CLS_NONE    = 2'b00,
        CLS_MAIN    = 2'b01,
        CLS_LOGIC   = 2'b10,
        CLS_THERMAL = 2'b11
    } fault_cls_t;

endpackage

// File: rtl/rail_fault_qualifier.sv
module rail_fault_qualifier (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic seq_done,
    input  logic dsw_low,
    input  logic short_boost,
    input  logic short_ppump,
    input  logic short_npump,
    input  logic short_logic,
    output logic main_flt,
    output logic logic_flt,
    output logic any_flt,
    output logic en_rise
);
    logic en_q;

    // Delayed switch still open after sequencing counts as a main-scope fault
    assign main_flt  = short_boost | short_ppump | short_npump | (seq_done & ~dsw_low);
    assign logic_flt = short_logic;
    assign any_flt   = main_flt | logic_flt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= en;
    end

    assign en_rise = en & ~en_q;
endmodule

// File: rtl/rail_fault_window_timer.sv
module rail_fault_window_timer #(
    parameter int unsigned WIN_CYCLES = 5_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic done
);
    localparam int unsigned CW = (WIN_CYCLES > 1) ? $clog2(WIN_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(WIN_CYCLES - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt <= '0;
        else if (clr)     cnt <= '0;
        else if (inc && cnt != LAST) cnt <= cnt + 1'b1;
    end

    assign done = (cnt == LAST);
endmodule

// File: rtl/rail_fault_fsm.sv
module rail_fault_fsm
    import rail_fault_supervisor_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       en_rise,
    input  logic       over_temp,
    input  logic       any_flt,
    input  logic       logic_flt,
    input  logic       win_done,
    output logic       win_clr,
    output logic       win_inc,
    output logic       main_off,
    output logic       logic_off,
    output logic [1:0] fault_class
);
    sup_state_t st, nxt;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= SUP_OFF;
        else        st <= nxt;
    end

    // Next state and window control
    always_comb begin
        nxt     = st;
        win_clr = 1'b1;
        win_inc = 1'b0;
        if (over_temp) begin
            nxt = SUP_HOT_TRIP;
        end else begin
            unique case (st)
                SUP_OFF: begin
                    if (en) nxt = SUP_ARMED;
                end
                SUP_ARMED: begin
                    if (!en)          nxt = SUP_OFF;
                    else if (any_flt) nxt = SUP_WINDOW;
                end
                SUP_WINDOW: begin
                    if (!en)           nxt = SUP_OFF;
                    else if (!any_flt) nxt = SUP_ARMED;
                    else if (win_done) nxt = logic_flt ? SUP_ALL_TRIP : SUP_MAIN_TRIP;
                    else begin
                        win_clr = 1'b0;
                        win_inc = 1'b1;
                    end
                end
                SUP_MAIN_TRIP: begin
                    if (en_rise)               nxt = SUP_ARMED;
                    else if (en && logic_flt)  nxt = SUP_LOGIC_WINDOW;
                end
                SUP_LOGIC_WINDOW: begin
                    if (en_rise)                  nxt = SUP_ARMED;
                    else if (!en || !logic_flt)   nxt = SUP_MAIN_TRIP;
                    else if (win_done)            nxt = SUP_ALL_TRIP;
                    else begin
                        win_clr = 1'b0;
                        win_inc = 1'b1;
                    end
                end
                SUP_ALL_TRIP, SUP_HOT_TRIP: begin
                    if (en_rise) nxt = SUP_ARMED;
                end
                default: nxt = SUP_OFF;
            endcase
        end
    end

    // Outputs decoded from the state
    always_comb begin
        main_off    = 1'b1;
        logic_off   = 1'b0;
        fault_class = CLS_NONE;
        unique case (st)
            SUP_OFF: ;
            SUP_ARMED, SUP_WINDOW: main_off = 1'b0;
            SUP_MAIN_TRIP, SUP_LOGIC_WINDOW: fault_class = CLS_MAIN;
            SUP_ALL_TRIP: begin
                logic_off   = 1'b1;
                fault_class = CLS_LOGIC;
            end
            SUP_HOT_TRIP: begin
                logic_off   = 1'b1;
                fault_class = CLS_THERMAL;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/rail_fault_supervisor.sv
module rail_fault_supervisor #(
    parameter int unsigned WIN_CYCLES = 5_000_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       seq_done,
    input  logic       dsw_low,
    input  logic       short_boost,
    input  logic       short_ppump,
    input  logic       short_npump,
    input  logic       short_logic,
    input  logic       over_temp,
    output logic       main_off,
    output logic       logic_off,
    output logic [1:0] fault_class
);
    logic main_flt, logic_flt, any_flt, en_rise;
    logic win_clr, win_inc, win_done;

    rail_fault_qualifier u_qual (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (en),
        .seq_done    (seq_done),
        .dsw_low     (dsw_low),
        .short_boost (short_boost),
        .short_ppump (short_ppump),
        .short_npump (short_npump),
        .short_logic (short_logic),
        .main_flt    (main_flt),
        .logic_flt   (logic_flt),
        .any_flt     (any_flt),
        .en_rise     (en_rise)
    );

    rail_fault_window_timer #(.WIN_CYCLES(WIN_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (win_clr),
        .inc   (win_inc),
        .done  (win_done)
    );

    rail_fault_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (en),
        .en_rise     (en_rise),
        .over_temp   (over_temp),
        .any_flt     (any_flt),
        .logic_flt   (logic_flt),
        .win_done    (win_done),
        .win_clr     (win_clr),
        .win_inc     (win_inc),
        .main_off    (main_off),
        .logic_off   (logic_off),
        .fault_class (fault_class)
    );

    logic unused_main;
    assign unused_main = main_flt;
endmodule

// File: rtl/rail_fault_supervisor_chk.sv
module rail_fault_supervisor_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       en,
    input logic       over_temp,
    input logic       main_off,
    input logic       logic_off,
    input logic [1:0] fault_class
);
    // R5
    thermal_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        over_temp |=> (logic_off && main_off && fault_class == 2'b11));

    // R2
    main_scope_keeps_logic_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_class == 2'b01) |-> (main_off && !logic_off));

    // R4
    logic_off_implies_main_chk: assert property (@(posedge clk) disable iff (!rst_n)
        logic_off |-> main_off);

    // R7
    latch_holds_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_class != 2'b00 && !en) |=> (fault_class != 2'b00));

    // R10
    disabled_ignores_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && fault_class == 2'b00 && !over_temp) |=> (fault_class == 2'b00 && main_off && !logic_off));

    // R9
    thermal_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_class == 2'b11 && over_temp) |=> (fault_class == 2'b11));
endmodule

bind rail_fault_supervisor rail_fault_supervisor_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .en          (en),
    .over_temp   (over_temp),
    .main_off    (main_off),
    .logic_off   (logic_off),
    .fault_class (fault_class)
);

// File: tb/rail_fault_supervisor_tb_top.sv
`timescale 1ns/1ps
module rail_fault_supervisor_tb_top;
    localparam int unsigned WIN = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0, seq_done = 1'b0, dsw_low = 1'b1;
    logic short_boost = 1'b0, short_ppump = 1'b0, short_npump = 1'b0, short_logic = 1'b0;
    logic over_temp = 1'b0;
    logic main_off, logic_off;
    logic [1:0] fault_class;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    rail_fault_supervisor #(.WIN_CYCLES(WIN)) dut_i (
        .clk(clk), .rst_n(rst_n), .en(en), .seq_done(seq_done), .dsw_low(dsw_low),
        .short_boost(short_boost), .short_ppump(short_ppump), .short_npump(short_npump),
        .short_logic(short_logic), .over_temp(over_temp),
        .main_off(main_off), .logic_off(logic_off), .fault_class(fault_class)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic expect_out(input string req, input logic mo, input logic lo, input logic [1:0] cls);
        n_chk++;
        if (main_off !== mo || logic_off !== lo || fault_class !== cls) begin
            n_bad++;
            $display("FAIL %s: got main_off=%b logic_off=%b class=%b, want %b %b %b",
                     req, main_off, logic_off, fault_class, mo, lo, cls);
        end
    endtask

    task automatic release_latch();
        en = 1'b0; step(2);
        en = 1'b1; step(1);
    endtask

    task automatic t_reset();
        step(1);
        expect_out("R1 reset", 1'b1, 1'b0, 2'b00);
        rst_n = 1'b1; step(2);
        expect_out("R1 enable low", 1'b1, 1'b0, 2'b00);
        en = 1'b1; step(1);
        expect_out("R1 enabled", 1'b0, 1'b0, 2'b00);
    endtask

    task automatic t_main_trip();
        short_ppump = 1'b1; step(WIN);
        expect_out("R2 before expiry", 1'b0, 1'b0, 2'b00);
        step(1);
        expect_out("R2 expiry", 1'b1, 1'b0, 2'b01);
        short_ppump = 1'b0; step(3);
        expect_out("R7 latch holds", 1'b1, 1'b0, 2'b01);
        en = 1'b0; step(3);
        expect_out("R7 hold en low", 1'b1, 1'b0, 2'b01);
        en = 1'b1; step(1);
        expect_out("R7 release", 1'b0, 1'b0, 2'b00);
    endtask

    task automatic t_clear_restart();
        short_npump = 1'b1; step(WIN);
        short_npump = 1'b0; step(1);
        expect_out("R3 no trip", 1'b0, 1'b0, 2'b00);
        short_boost = 1'b1; step(WIN);
        expect_out("R3 restarted window", 1'b0, 1'b0, 2'b00);
        step(1);
        expect_out("R3 full window trip", 1'b1, 1'b0, 2'b01);
        short_boost = 1'b0; release_latch();
        expect_out("R7 release 2", 1'b0, 1'b0, 2'b00);
    endtask

    task automatic t_logic_trip();
        short_logic = 1'b1; step(WIN);
        expect_out("R4 before expiry", 1'b0, 1'b0, 2'b00);
        step(1);
        expect_out("R4 expiry", 1'b1, 1'b1, 2'b10);
        short_logic = 1'b0; release_latch();
        expect_out("R7 release logic", 1'b0, 1'b0, 2'b00);
    endtask

    task automatic t_upgrade();
        short_boost = 1'b1; step(WIN + 1);
        expect_out("R8 main first", 1'b1, 1'b0, 2'b01);
        short_logic = 1'b1; step(WIN);
        expect_out("R8 logic window running", 1'b1, 1'b0, 2'b01);
        step(1);
        expect_out("R8 upgrade", 1'b1, 1'b1, 2'b10);
        short_boost = 1'b0; short_logic = 1'b0; release_latch();
        expect_out("R8 release", 1'b0, 1'b0, 2'b00);
    endtask

    task automatic t_thermal();
        over_temp = 1'b1; step(1);
        expect_out("R5 immediate", 1'b1, 1'b1, 2'b11);
        over_temp = 1'b0; step(3);
        expect_out("R5 latched", 1'b1, 1'b1, 2'b11);
        release_latch();
        expect_out("R5 release", 1'b0, 1'b0, 2'b00);
    endtask

    task automatic t_collision();
        short_boost = 1'b1; step(WIN);
        over_temp = 1'b1; step(1);
        expect_out("R9 thermal beats expiry", 1'b1, 1'b1, 2'b11);
        short_boost = 1'b0;
        en = 1'b0; step(2); en = 1'b1; step(1);
        expect_out("R9 thermal beats release", 1'b1, 1'b1, 2'b11);
        over_temp = 1'b0; release_latch();
        expect_out("R9 release", 1'b0, 1'b0, 2'b00);
    endtask

    task automatic t_delayed_switch();
        seq_done = 1'b1; dsw_low = 1'b1; step(2 * WIN);
        expect_out("R6 switch ok", 1'b0, 1'b0, 2'b00);
        dsw_low = 1'b0; step(WIN);
        expect_out("R6 before expiry", 1'b0, 1'b0, 2'b00);
        step(1);
        expect_out("R6 switch fault trip", 1'b1, 1'b0, 2'b01);
        dsw_low = 1'b1; release_latch();
        expect_out("R6 release", 1'b0, 1'b0, 2'b00);
    endtask

    task automatic t_disabled();
        en = 1'b0; step(1);
        short_boost = 1'b1; short_logic = 1'b1; step(3 * WIN);
        expect_out("R10 faults ignored", 1'b1, 1'b0, 2'b00);
        short_boost = 1'b0; short_logic = 1'b0; step(1);
        en = 1'b1; step(1);
        expect_out("R10 re-enable", 1'b0, 1'b0, 2'b00);
    endtask

    initial begin
        t_reset();
        t_main_trip();
        t_clear_restart();
        t_logic_trip();
        t_upgrade();
        t_thermal();
        t_collision();
        t_delayed_switch();
        t_disabled();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #2_000_000;
        if (!finished) begin
            finished = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout, want completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule